// File: doc/BRIEF.md
# Indexed System-Control Register Bank

This block is the register file that a processor's system-control coprocessor presents to a debug-style access port. Each access carries a 4-bit register number, a 2-bit sub-selector, a write flag qualified by a valid strobe, and 32 bits of write data. Most register numbers map to plain storage, and some are banked by the sub-selector. Register 0 returns three constant identification words.

Registers 7 and 8 hold no state. A write to either one is decoded into a single-cycle, one-hot maintenance pulse for caches or TLBs. The pulse comes with an address operand taken from the write data, with the selector bits cleared. The caches, TLBs and pipeline that would consume these pulses lie outside the block.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, every writable location reads as zero, `op_pulse` is all zero, and `rd_valid` and `op_invalid` are low.
- R2: Register 0 is read-only. Sub-selector 0 returns `ID_WORD`, 1 returns `CACHE_WORD`, 2 returns `TCM_WORD` and 3 returns zero. A write to register 0 leaves all of these unchanged.
- R3: Registers 1, 2, 3, 6 and 10 are each one 32-bit read/write word that ignores the sub-selector. A write with any sub-selector is seen by a read with any other sub-selector.
- R4: The following are separate read/write words, one per sub-selector value: register 5 for sub-selectors 0 and 1, register 9 for sub-selectors 0 to 3, register 13 for sub-selectors 0 and 1, and register 15 for sub-selectors 0 and 1.
- R5: Reads of the following return zero, and writes to them change no readable word:
  - registers 4, 11, 12 and 14;
  - registers 5, 13 and 15 with sub-selector 2 or 3;
  - registers 7 and 8 (reads only).
- R6: A read strobe in cycle N gives `rd_valid` high in cycle N+1 with its data. `rd_valid` is low in every cycle that does not follow a read strobe. A read directly after a write to the same word returns the new value.
- R7: A register 7 write selects an `op_pulse` bit from the sub-selector and write data bits [2:0]:
  - sub-selector 1: 000→bit0, 001→bit1, 010→bit2, 011→bit3, 100→bit4, 101→bit5;
  - sub-selector 2: 000→bit6, 001→bit7, 011→bit8, 110→bit5;
  - sub-selector 0: 000→bit9, 001→bit10, 011→bit11.
- R8: A register 8 write selects an `op_pulse` bit as base + data bit 0. The base is 12 for sub-selector 2 (both TLBs), 14 for sub-selector 1 (I-TLB) and 16 for sub-selector 0 (D-TLB). Bit 0 = 0 means whole-TLB invalidate and bit 0 = 1 means a single entry by address.
- R9: With a register 7 pulse, `op_operand` equals the write data with bits [2:0] zeroed. With a register 8 pulse, it equals the write data with bit 0 zeroed.
- R10: A register 7 or 8 write in cycle N raises exactly one `op_pulse` bit in cycle N+1, for that cycle only. If the register 7 or 8 combination is not listed in R7 or R8, `op_invalid` is raised in cycle N+1 instead and no pulse bit is set.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 4 | Register number |
| acc_sel | input | 2 | Sub-selector |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| op_pulse | output | 18 | One-hot maintenance operation pulse |
| op_operand | output | 32 | Cleaned operand presented with the pulse |
| op_invalid | output | 1 | Unlisted maintenance combination was written |

## Verification
Two things can land in the same output cycle. One is a maintenance pulse from a register 7 or 8 write. The other is the launch of the next access, which can be a read whose data must still appear alone one cycle later. The bench provokes this with back-to-back streams that alternate maintenance writes, storage writes and reads of the word just written.

A scoreboard entry is pushed for every cycle. In each cycle the monitor judges the pulse vector, the operand, the invalid flag and the read data together, so a pulse that leaks into a neighbouring cycle, or a read that returns stale data after a write, is reported against its requirement.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW     = 32;
  localparam int REG_W  = 4;
  localparam int SEL_W  = 2;
  localparam int NSLOT  = 15;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int NOPS   = 18;

  // operation bit positions on op_pulse
  localparam int OP_C_INV_BOTH = 0;
  localparam int OP_C_INV_I    = 1;
  localparam int OP_C_INV_I_VA = 2;
  localparam int OP_C_INV_I_SW = 3;
  localparam int OP_C_PREF_I   = 4;
  localparam int OP_C_DRAIN    = 5;
  localparam int OP_C_TCI_D    = 6;
  localparam int OP_C_CI_D_VA  = 7;
  localparam int OP_C_CI_D_SW  = 8;
  localparam int OP_C_INV_D    = 9;
  localparam int OP_C_INV_D_VA = 10;
  localparam int OP_C_TC_D     = 11;
  localparam int OP_T_BOTH     = 12;
  localparam int OP_T_I        = 14;
  localparam int OP_T_D        = 16;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  typedef logic [NSLOT-1:0][DW-1:0] slot_arr_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [REG_W-1:0] reg_num,
  input  logic [SEL_W-1:0] sel,
  output slot_t            slot
);
  always_comb begin
    slot = '0;
    unique case (reg_num)
      4'd1:  begin slot.hit = 1'b1; slot.idx = SLOT_W'(0); end
      4'd2:  begin slot.hit = 1'b1; slot.idx = SLOT_W'(1); end
      4'd3:  begin slot.hit = 1'b1; slot.idx = SLOT_W'(2); end
      4'd5:  begin slot.hit = ~sel[1]; slot.idx = SLOT_W'(3) + SLOT_W'(sel[0]); end
      4'd6:  begin slot.hit = 1'b1; slot.idx = SLOT_W'(5); end
      4'd9:  begin slot.hit = 1'b1; slot.idx = SLOT_W'(6) + SLOT_W'(sel); end
      4'd10: begin slot.hit = 1'b1; slot.idx = SLOT_W'(10); end
      4'd13: begin slot.hit = ~sel[1]; slot.idx = SLOT_W'(11) + SLOT_W'(sel[0]); end
      4'd15: begin slot.hit = ~sel[1]; slot.idx = SLOT_W'(13) + SLOT_W'(sel[0]); end
      default: slot = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_slot_store.sv
module sysctl_slot_store
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  slot_t         wr_slot,
  input  logic [DW-1:0] wr_data,
  output slot_arr_t     slots
);
  slot_arr_t slots_q;
  slot_arr_t slots_d;
  logic [NSLOT-1:0] slot_en;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_comb begin
      slot_en[i] = wr_en && wr_slot.hit && (wr_slot.idx == SLOT_W'(i));
      slots_d[i] = slot_en[i] ? wr_data : slots_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slots_q[i] <= '0;
      else if (slot_en[i]) slots_q[i] <= slots_d[i];
    end
  end

  assign slots = slots_q;

  // R5: a cycle without a write enable leaves every word unchanged
  a_r5_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_slot.hit) |=> $stable(slots_q));
  // R4: one write touches at most one word
  a_r4_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_en));
endmodule

// File: rtl/sysctl_maint_dec.sv
module sysctl_maint_dec
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] reg_num,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  output logic [NOPS-1:0]  op_pulse,
  output logic [DW-1:0]    op_operand,
  output logic             op_invalid
);
  logic            is_cache, is_tlb;
  logic [NOPS-1:0] pulse_d, pulse_q;
  logic [DW-1:0]   opnd_d, opnd_q;
  logic            inv_d, inv_q;
  int              idx;

  always_comb begin
    is_cache = wr_en && (reg_num == 4'd7);
    is_tlb   = wr_en && (reg_num == 4'd8);
    idx      = -1;
    if (is_cache) begin
      unique case ({sel, wdata[2:0]})
        5'b01_000: idx = OP_C_INV_BOTH;
        5'b01_001: idx = OP_C_INV_I;
        5'b01_010: idx = OP_C_INV_I_VA;
        5'b01_011: idx = OP_C_INV_I_SW;
        5'b01_100: idx = OP_C_PREF_I;
        5'b01_101: idx = OP_C_DRAIN;
        5'b10_000: idx = OP_C_TCI_D;
        5'b10_001: idx = OP_C_CI_D_VA;
        5'b10_011: idx = OP_C_CI_D_SW;
        5'b10_110: idx = OP_C_DRAIN;
        5'b00_000: idx = OP_C_INV_D;
        5'b00_001: idx = OP_C_INV_D_VA;
        5'b00_011: idx = OP_C_TC_D;
        default:   idx = -1;
      endcase
    end else if (is_tlb) begin
      unique case (sel)
        2'd2:    idx = OP_T_BOTH + int'(wdata[0]);
        2'd1:    idx = OP_T_I + int'(wdata[0]);
        2'd0:    idx = OP_T_D + int'(wdata[0]);
        default: idx = -1;
      endcase
    end

    pulse_d = '0;
    opnd_d  = '0;
    inv_d   = 1'b0;
    if (is_cache || is_tlb) begin
      if (idx < 0) begin
        inv_d = 1'b1;
      end else begin
        pulse_d[idx] = 1'b1;
        opnd_d = is_cache ? {wdata[DW-1:3], 3'b000} : {wdata[DW-1:1], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      opnd_q  <= '0;
      inv_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      opnd_q  <= opnd_d;
      inv_q   <= inv_d;
    end
  end

  assign op_pulse   = pulse_q;
  assign op_operand = opnd_q;
  assign op_invalid = inv_q;

  // R10: never more than one operation at a time
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));
  // R10: any pulse or invalid flag follows a maintenance write
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 || inv_q) |-> $past(wr_en && (reg_num == 4'd7 || reg_num == 4'd8)));
  // R10: invalid flag excludes every pulse
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> (pulse_q == '0));
  // R9: cache operands carry clear low bits, TLB operands clear bit 0
  a_r9_cache_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q[OP_C_TC_D:0] != '0) |-> (opnd_q[2:0] == 3'b000));
  a_r9_tlb_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q[NOPS-1:OP_T_BOTH] != '0) |-> (opnd_q[0] == 1'b0));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h5A01_0001,
  parameter logic [31:0] CACHE_WORD = 32'h0C1D_2004,
  parameter logic [31:0] TCM_WORD   = 32'h0000_0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [REG_W-1:0] acc_reg,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [DW-1:0]    acc_wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [NOPS-1:0]  op_pulse,
  output logic [DW-1:0]    op_operand,
  output logic             op_invalid
);
  logic [1:0]    rst_sync;
  logic          srst_n;
  slot_t         slot;
  slot_arr_t     slots;
  logic          wr_en, rd_en;
  logic [DW-1:0] rd_data_d, rd_data_q;
  logic          rd_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  assign wr_en = acc_valid && acc_write;
  assign rd_en = acc_valid && !acc_write;

  sysctl_addr_dec u_dec (
    .reg_num (acc_reg),
    .sel     (acc_sel),
    .slot    (slot)
  );

  sysctl_slot_store u_store (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_slot (slot),
    .wr_data (acc_wdata),
    .slots   (slots)
  );

  sysctl_maint_dec u_maint (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .reg_num    (acc_reg),
    .sel        (acc_sel),
    .wdata      (acc_wdata),
    .op_pulse   (op_pulse),
    .op_operand (op_operand),
    .op_invalid (op_invalid)
  );

  always_comb begin
    rd_data_d = '0;
    if (acc_reg == 4'd0) begin
      unique case (acc_sel)
        2'd0:    rd_data_d = ID_WORD;
        2'd1:    rd_data_d = CACHE_WORD;
        2'd2:    rd_data_d = TCM_WORD;
        default: rd_data_d = '0;
      endcase
    end else if (slot.hit) begin
      for (int i = 0; i < NSLOT; i++)
        if (slot.idx == SLOT_W'(i)) rd_data_d = slots[i];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R6: read data is valid exactly one cycle after a read strobe
  a_r6_rd_timing: assert property (@(posedge clk) disable iff (!srst_n)
    rd_valid_q == $past(rd_en));
  // R2: an identification read returns the configured constant
  a_r2_id_read: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && acc_reg == 4'd0 && acc_sel == 2'd0) |=> (rd_data_q == ID_WORD));
  // R5: reads of the maintenance registers return zero
  a_r5_maint_read: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && (acc_reg == 4'd7 || acc_reg == 4'd8)) |=> (rd_data_q == '0));
endmodule

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
  localparam logic [31:0] IDW = 32'h5A01_0001;
  localparam logic [31:0] CCW = 32'h0C1D_2004;
  localparam logic [31:0] TCW = 32'h0000_0011;

  logic        clk, rst_n;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_reg;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [17:0] op_pulse;
  logic [31:0] op_operand;
  logic        op_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          rdv;
    logic [31:0] rdd;
    logic [17:0] ops;
    logic [31:0] opnd;
    bit          inv;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] mdl [0:15][0:3];

  sysctl_regbank u0 (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic bit plain_reg(input int r);
    return r == 1 || r == 2 || r == 3 || r == 6 || r == 10;
  endfunction

  function automatic bit store_loc(input int r, input int s);
    if (plain_reg(r)) return 1;
    if (r == 9) return 1;
    if ((r == 5 || r == 13 || r == 15) && s < 2) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] read_exp(input int r, input int s);
    if (r == 0) return (s == 0) ? IDW : (s == 1) ? CCW : (s == 2) ? TCW : 32'h0;
    if (!store_loc(r, s)) return 32'h0;
    return mdl[r][plain_reg(r) ? 0 : s];
  endfunction

  function automatic int op_exp(input int r, input int s, input logic [31:0] d);
    if (r == 7) begin
      case (s)
        1: return (d[2:0] <= 3'd5) ? int'(d[2:0]) : -1;
        2: case (d[2:0]) 3'd0: return 6; 3'd1: return 7; 3'd3: return 8; 3'd6: return 5; default: return -1; endcase
        0: case (d[2:0]) 3'd0: return 9; 3'd1: return 10; 3'd3: return 11; default: return -1; endcase
        default: return -1;
      endcase
    end
    if (s == 3) return -1;
    return ((s == 2) ? 12 : (s == 1) ? 14 : 16) + int'(d[0]);
  endfunction

  task automatic access(input bit w, input int r, input int s, input logic [31:0] d, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_reg = 4'(r); acc_sel = 2'(s); acc_wdata = d;
    e.rdv = !w; e.rdd = w ? 32'h0 : read_exp(r, s);
    e.ops = '0; e.opnd = '0; e.inv = 0; e.tag = tag;
    if (w && (r == 7 || r == 8)) begin
      k = op_exp(r, s, d);
      if (k < 0) e.inv = 1;
      else begin
        e.ops[k] = 1'b1;
        e.opnd = (r == 7) ? {d[31:3], 3'b000} : {d[31:1], 1'b0};
      end
    end
    if (w && store_loc(r, s)) mdl[r][plain_reg(r) ? 0 : s] = d;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    e.rdv = 0; e.rdd = 0; e.ops = '0; e.opnd = '0; e.inv = 0; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rd_valid !== e.rdv || (e.rdv && rd_data !== e.rdd) ||
            op_pulse !== e.ops || op_invalid !== e.inv ||
            (e.ops != '0 && op_operand !== e.opnd)) begin
          fails++;
          $display("FAIL %s: got rdv=%0b rd=%h ops=%h opnd=%h inv=%0b exp rdv=%0b rd=%h ops=%h opnd=%h inv=%0b",
                   e.tag, rd_valid, rd_data, op_pulse, op_operand, op_invalid,
                   e.rdv, e.rdd, e.ops, e.opnd, e.inv);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) for (int s = 0; s < 4; s++) mdl[r][s] = 32'h0;
    acc_valid = 0; acc_write = 0; acc_reg = 0; acc_sel = 0; acc_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (rd_valid !== 1'b0 || op_pulse !== '0 || op_invalid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got rdv=%0b ops=%h inv=%0b exp 0 0 0", rd_valid, op_pulse, op_invalid);
    end

    // R1: every location reads zero (or its constant) after reset
    for (int r = 0; r < 16; r++) for (int s = 0; s < 4; s++) access(0, r, s, 32'h0, "R1");
    idle("R6");

    // R2: identification words, writes ignored
    for (int s = 0; s < 4; s++) access(0, 0, s, 32'h0, "R2");
    for (int s = 0; s < 4; s++) access(1, 0, s, 32'hDEAD_BEEF, "R2");
    for (int s = 0; s < 4; s++) access(0, 0, s, 32'h0, "R2");

    // R3: plain words ignore the sub-selector
    foreach (mdl[r]) if (plain_reg(r)) begin
      access(1, r, 2, 32'h1000_0000 + 32'(r), "R3");
      for (int s = 0; s < 4; s++) access(0, r, s, 32'h0, "R3");
    end

    // R4: banked words are separate
    for (int s = 0; s < 4; s++) begin
      access(1, 5, s, 32'h5500_0000 + 32'(s), "R4");
      access(1, 9, s, 32'h9900_0000 + 32'(s), "R4");
      access(1, 13, s, 32'hD000_0000 + 32'(s), "R4");
      access(1, 15, s, 32'hF000_0000 + 32'(s), "R4");
    end
    for (int s = 0; s < 4; s++) begin
      access(0, 5, s, 0, "R4"); access(0, 9, s, 0, "R4");
      access(0, 13, s, 0, "R4"); access(0, 15, s, 0, "R4");
    end

    // R5: unmapped locations
    foreach (mdl[r]) if (r == 4 || r == 11 || r == 12 || r == 14) begin
      access(1, r, 1, 32'hFFFF_FFFF, "R5");
      access(0, r, 1, 0, "R5");
    end
    for (int r = 1; r < 16; r++) for (int s = 0; s < 4; s++) access(0, r, s, 0, "R5");

    // R6: back-to-back write then read, interleaved with maintenance
    for (int i = 0; i < 8; i++) begin
      access(1, 6, i % 4, 32'hA5A5_0000 ^ 32'(i * 77), "R6");
      access(0, 6, (i + 1) % 4, 0, "R6");
      access(1, 7, 1, 32'h0000_1238 | 32'(i % 6), "R10");
      access(0, 9, i % 4, 0, "R6");
      idle("R6");
    end

    // R7/R9/R10: every register 7 combination
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 8; b++) begin
        access(1, 7, s, 32'hFFFF_FFF8 | 32'(b), "R7");
        access(1, 7, s, 32'h1234_5670 | 32'(b), "R9");
      end
    idle("R10");

    // R8/R9/R10: every register 8 combination
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++) begin
        access(1, 8, s, 32'hFFFF_FFFE | 32'(b), "R8");
        access(1, 8, s, 32'h8765_4320 | 32'(b), "R9");
        idle("R10");
      end

    // R5: maintenance writes did not reach any storage
    for (int r = 1; r < 16; r++) for (int s = 0; s < 4; s++) access(0, r, s, 0, "R5");
    repeat (3) idle("R10");
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule